// File: doc/BRIEF.md
# Configuration Controller Command Sequencer

This block drives the memory-mapped host port of a dual-image configuration controller. After a single start request it runs a fixed command sequence. First it writes a trigger to one register. It then leaves the port fully quiet for a programmable number of cycles. Next it writes a one-hot image selection word to a second register. Finally it reads a status register until that register's busy flag drops. Each step of the sequence occupies exactly one clock cycle, and the sequencer shares its clock with the controller.

Every write is two cycles long. In the first cycle address and data are presented with the write strobe low. In the second cycle the strobe is raised while address and data stay as they were. Any port signal that a step does not name is driven to zero. The quiet gap after the trigger write defaults to three cycles, because shorter gaps are unreliable on the controller side.

When the busy flag is seen low, the block pulses `done_o` for one cycle and returns to idle. An optional poll limit ends a stuck poll and raises a sticky error flag, which stays up until the next accepted start.

Top module: `cfg_seq`

## Requirements
- R1: With `rst_n` low at a clock edge, the block goes idle. In idle `addr_o`, `wdata_o`, `wr_o`, `rd_o`, `done_o`, `busy_o` and `err_o` are all zero, including when reset lands in the middle of a sequence.
- R2: The cycle after a start is taken, the port shows address 0 with data 0x1 and `wr_o` low. The next cycle shows the same address and data with `wr_o` high.
- R3: After the trigger write the port stays all-zero (address, data, both strobes) for exactly GAP_CYCLES cycles while `busy_o` is high.
- R4: After the gap the port shows address 2 with data `1 << idx` and `wr_o` low for one cycle. The next cycle repeats the same address and data with `wr_o` high. `idx` is the 2-bit value of `sel_i` when start was taken.
- R5: After the selection write the port reads address 3 with `rd_o` high. The first read cycle is never judged. The read is then repeated, and bit 0 of `rdata_i` (the busy flag) is judged in every repeat cycle until it is seen 0. Bits 31:1 have no effect.
- R6: In the cycle after the busy flag is seen 0, `done_o` is high for exactly one cycle with all port outputs zero, then the block is idle. `busy_o` is high in every cycle from the first trigger-write cycle through the last read cycle, and low while `done_o` is high.
- R7: `start_i` has an effect only in idle. A start pulse and any change of `sel_i` during a sequence leave that sequence's port activity and timing unchanged.
- R8: With the poll limit enabled, if the flag is still 1 in the TIMEOUT_CYCLES-th repeat read cycle, the poll ends. The `done_o` pulse follows and `err_o` goes high with it. `err_o` stays high until the next accepted start, which clears it. A flag that drops in exactly that last allowed cycle completes without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the controller |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to run one sequence (taken in idle only) |
| sel_i | input | 2 | Index of the selection bit to set |
| addr_o | output | 3 | Host port register address |
| wdata_o | output | 32 | Host port write data |
| wr_o | output | 1 | Host port write strobe |
| rd_o | output | 1 | Host port read strobe |
| rdata_i | input | 32 | Host port read data; bit 0 is the busy flag at address 3 |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | High while a sequence is in progress |
| err_o | output | 1 | Sticky poll-limit error flag |

## Verification
The bench builds the block with GAP_CYCLES=4 rather than the default, which shows that the quiet gap follows the parameter. It sets TIMEOUT_CYCLES=8, which makes the poll limit cheap to reach. That allows a stuck flag of 12 cycles to force the error path, while a flag that clears after exactly 8 cycles probes the last allowed poll cycle. The controller model holds the flag busy for a chosen number of cycles after the selection write, so zero, one, several and limit-length waits are all exercised.

// File: rtl/cfg_seq_pkg.sv
// Package: shared state encoding and register addresses for the
// configuration command sequencer. Assumes a 3-bit host address space.
package cfg_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_TRIG_SET = 4'd1,
        ST_TRIG_WR  = 4'd2,
        ST_GAP      = 4'd3,
        ST_SEL_SET  = 4'd4,
        ST_SEL_WR   = 4'd5,
        ST_RD_FIRST = 4'd6,
        ST_RD_POLL  = 4'd7,
        ST_DONE     = 4'd8
    } seq_state_e;

    localparam logic [2:0] REG_TRIGGER = 3'd0;
    localparam logic [2:0] REG_SELECT  = 3'd2;
    localparam logic [2:0] REG_STATUS  = 3'd3;

endpackage

// File: rtl/cfg_seq_fsm.sv
// Module: sequencing core. Steps through the command sequence one state
// per clock, counts the quiet gap, latches the selection index on an
// accepted start and keeps the sticky error flag.
// Assumes GAP_CYCLES >= 1 and a synchronous active-low reset.
module cfg_seq_fsm
    import cfg_seq_pkg::*;
#(
    parameter int GAP_CYCLES = 3,
    parameter int IDX_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] sel_i,
    input  logic             flag_i,
    input  logic             expired_i,
    output seq_state_e       state_o,
    output logic [IDX_W-1:0] sel_q_o,
    output logic             err_o
);

    localparam int GAP_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYCLES - 1);

    seq_state_e       state_q, state_d;
    logic [GAP_W-1:0] gap_q;

    // Next-state selection for the command sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_TRIG_SET;
            ST_TRIG_SET: state_d = ST_TRIG_WR;
            ST_TRIG_WR:  state_d = ST_GAP;
            ST_GAP:      if (gap_q == GAP_LAST) state_d = ST_SEL_SET;
            ST_SEL_SET:  state_d = ST_SEL_WR;
            ST_SEL_WR:   state_d = ST_RD_FIRST;
            ST_RD_FIRST: state_d = ST_RD_POLL;
            ST_RD_POLL:  if (!flag_i || expired_i) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Quiet-gap counter, cleared outside the gap state.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_GAP) gap_q <= '0;
        else                             gap_q <= gap_q + 1'b1;
    end

    // Selection index latch, loaded only when a start is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)                           sel_q_o <= '0;
        else if (state_q == ST_IDLE && start_i) sel_q_o <= sel_i;
    end

    // Sticky error: set on poll expiry, cleared by the next accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   err_o <= 1'b0;
        else if (state_q == ST_IDLE && start_i)       err_o <= 1'b0;
        else if (state_q == ST_RD_POLL && flag_i && expired_i) err_o <= 1'b1;
    end

    assign state_o = state_q;

endmodule

// File: rtl/cfg_seq_limit.sv
// Module: poll limit. Counts repeat-read cycles that see the flag set and
// signals expiry in the last allowed one. With LIMIT_EN = 0 the expiry
// output is tied low. Assumes TIMEOUT_CYCLES >= 1.
module cfg_seq_limit #(
    parameter bit LIMIT_EN       = 1'b1,
    parameter int TIMEOUT_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic polling_i,
    input  logic flag_i,
    output logic expired_o
);

    localparam int CNT_W = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    generate
        if (LIMIT_EN) begin : g_limit
            logic [CNT_W-1:0] cnt_q;

            // Cycle counter for the poll phase, cleared outside it.
            always_ff @(posedge clk) begin
                if (!rst_n || !polling_i) cnt_q <= '0;
                else if (flag_i)          cnt_q <= cnt_q + 1'b1;
            end

            assign expired_o = polling_i && flag_i && (cnt_q == CNT_LAST);
        end else begin : g_nolimit
            assign expired_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/cfg_seq_port.sv
// Module: host port decode. Maps the current state to address, data and
// strobes, and drives zero on every signal a state does not name.
// Purely combinational from the state register, so each state is one cycle.
module cfg_seq_port
    import cfg_seq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  seq_state_e        state_i,
    input  logic [IDX_W-1:0]  sel_q_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              wr_o,
    output logic              rd_o,
    output logic              done_o,
    output logic              busy_o
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    // Per-state output decode with zero defaults.
    always_comb begin
        addr_o  = '0;
        wdata_o = '0;
        wr_o    = 1'b0;
        rd_o    = 1'b0;
        done_o  = 1'b0;
        busy_o  = 1'b1;
        unique case (state_i)
            ST_IDLE: busy_o = 1'b0;
            ST_TRIG_SET, ST_TRIG_WR: begin
                addr_o  = ADDR_W'(REG_TRIGGER);
                wdata_o = ONE;
                wr_o    = (state_i == ST_TRIG_WR);
            end
            ST_GAP: ;
            ST_SEL_SET, ST_SEL_WR: begin
                addr_o  = ADDR_W'(REG_SELECT);
                wdata_o = ONE << sel_q_i;
                wr_o    = (state_i == ST_SEL_WR);
            end
            ST_RD_FIRST, ST_RD_POLL: begin
                addr_o = ADDR_W'(REG_STATUS);
                rd_o   = 1'b1;
            end
            ST_DONE: begin
                busy_o = 1'b0;
                done_o = 1'b1;
            end
            default: busy_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/cfg_seq.sv
// Module: top of the configuration command sequencer. Ties the sequencing
// core, the poll limit and the port decode together. Assumes the
// controller runs on the same clock; bit 0 of read data is its busy flag.
module cfg_seq
    import cfg_seq_pkg::*;
#(
    parameter int ADDR_W         = 3,
    parameter int DATA_W         = 32,
    parameter int IDX_W          = 2,
    parameter int GAP_CYCLES     = 3,
    parameter bit LIMIT_EN       = 1'b1,
    parameter int TIMEOUT_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  sel_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              wr_o,
    output logic              rd_o,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              done_o,
    output logic              busy_o,
    output logic              err_o
);

    seq_state_e       state;
    logic [IDX_W-1:0] sel_q;
    logic             expired;
    logic             flag;

    assign flag = rdata_i[0];

    cfg_seq_fsm #(.GAP_CYCLES(GAP_CYCLES), .IDX_W(IDX_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_i),
        .flag_i(flag), .expired_i(expired),
        .state_o(state), .sel_q_o(sel_q), .err_o(err_o)
    );

    cfg_seq_limit #(.LIMIT_EN(LIMIT_EN), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) limit_i (
        .clk(clk), .rst_n(rst_n), .polling_i(state == ST_RD_POLL),
        .flag_i(flag), .expired_o(expired)
    );

    cfg_seq_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) port_i (
        .state_i(state), .sel_q_i(sel_q),
        .addr_o(addr_o), .wdata_o(wdata_o), .wr_o(wr_o), .rd_o(rd_o),
        .done_o(done_o), .busy_o(busy_o)
    );

endmodule

// File: rtl/cfg_seq_chk.sv
// Module: protocol checker for the sequencer's host port, bound to the top.
// Counts quiet cycles after the trigger write to judge the gap length.
module cfg_seq_chk #(
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 32,
    parameter int GAP_CYCLES = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_o,
    input logic [DATA_W-1:0] wdata_o,
    input logic              wr_o,
    input logic              rd_o,
    input logic [DATA_W-1:0] rdata_i,
    input logic              done_o,
    input logic              busy_o,
    input logic              err_o
);

    localparam int QW = $clog2(GAP_CYCLES + 2);
    localparam logic [QW-1:0] QMAX = QW'(GAP_CYCLES + 1);

    logic [QW-1:0] quiet_q;
    logic          quiet;

    assign quiet = busy_o && !wr_o && !rd_o && addr_o == '0 && wdata_o == '0;

    // Saturating count of quiet busy cycles since the last trigger write.
    always_ff @(posedge clk) begin
        if (!rst_n || (wr_o && addr_o == ADDR_W'(0))) quiet_q <= '0;
        else if (quiet && quiet_q != QMAX)             quiet_q <= quiet_q + 1'b1;
    end

    AST_WR_HOLDS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> $stable(addr_o) && $stable(wdata_o) && !$past(wr_o)); // R2
    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_o && rd_o)); // R5
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_o && addr_o == ADDR_W'(2)) |-> $countones(wdata_o) == 1); // R4
    AST_GAP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && addr_o == ADDR_W'(2) && !wr_o) |-> quiet_q == QW'(GAP_CYCLES)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o); // R6
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !wr_o && !rd_o); // R6
    AST_DONE_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> $past(rd_o) && !$past(rdata_i[0])); // R5
    AST_ERR_ONLY_ON_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o && $past(rd_o) && $past(rdata_i[0])); // R8

endmodule

bind cfg_seq cfg_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAP_CYCLES(GAP_CYCLES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .addr_o(addr_o), .wdata_o(wdata_o),
    .wr_o(wr_o), .rd_o(rd_o), .rdata_i(rdata_i), .done_o(done_o),
    .busy_o(busy_o), .err_o(err_o)
);

// File: tb/cfg_seq_tb_top.sv
`timescale 1ns/1ps
// Bench: scoreboard. A driver task queues the expected port image of every
// cycle of a sequence; a monitor pops and compares one image per cycle.
module cfg_seq_tb_top;

    localparam int GAP = 4;
    localparam int TO  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  sel_i = 2'd0;
    logic [2:0]  addr_o;
    logic [31:0] wdata_o;
    logic        wr_o, rd_o, done_o, busy_o, err_o;
    logic [31:0] rdata_i;

    int total = 0;
    int bad   = 0;
    int model_b = 0;
    int flag_cnt = 0;
    bit finished = 0;

    typedef struct packed {
        logic [2:0]  a;
        logic [31:0] d;
        logic        wr, rd, done, busy, err;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    cfg_seq #(.GAP_CYCLES(GAP), .TIMEOUT_CYCLES(TO)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_i),
        .addr_o(addr_o), .wdata_o(wdata_o), .wr_o(wr_o), .rd_o(rd_o),
        .rdata_i(rdata_i), .done_o(done_o), .busy_o(busy_o), .err_o(err_o)
    );

    // Controller model: busy for model_b cycles after the selection strobe.
    always @(posedge clk) begin
        if (!rst_n)                        flag_cnt <= 0;
        else if (wr_o && addr_o == 3'd2)   flag_cnt <= model_b;
        else if (flag_cnt != 0)            flag_cnt <= flag_cnt - 1;
    end
    assign rdata_i = (rd_o && addr_o == 3'd3) ? {31'h2D2D2D2D, flag_cnt != 0} : 32'h0;

    function automatic exp_t cur();
        return '{a: addr_o, d: wdata_o, wr: wr_o, rd: rd_o,
                 done: done_o, busy: busy_o, err: err_o};
    endfunction

    task automatic check(input exp_t e, input string tag);
        exp_t g = cur();
        total++;
        if (g !== e) begin
            bad++;
            $display("FAIL %s: got a=%0d d=%h wr=%b rd=%b done=%b busy=%b err=%b exp a=%0d d=%h wr=%b rd=%b done=%b busy=%b err=%b",
                     tag, g.a, g.d, g.wr, g.rd, g.done, g.busy, g.err,
                     e.a, e.d, e.wr, e.rd, e.done, e.busy, e.err);
        end
    endtask

    // Monitor: one comparison per clock, sampled 1 ns after the edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) check(exp_q.pop_front(), tag_q.pop_front());
    end

    task automatic push(input logic [2:0] a, input logic [31:0] d, input logic wr,
                        input logic rd, input logic dn, input logic bz,
                        input logic er, input string tag);
        exp_q.push_back('{a: a, d: d, wr: wr, rd: rd, done: dn, busy: bz, err: er});
        tag_q.push_back(tag);
    endtask

    // Driver: start one sequence and queue its expected cycle images.
    task automatic run(input int idx, input int b, input bit disturb);
        int  n  = (b == 0) ? 1 : ((b > TO) ? TO : b);
        bit  to = (b > TO);
        @(negedge clk);
        model_b = b;
        start_i = 1'b1;
        sel_i   = 2'(idx);
        push(3'd0, 32'h1, 0, 0, 0, 1, 0, disturb ? "R7" : "R2");
        push(3'd0, 32'h1, 1, 0, 0, 1, 0, disturb ? "R7" : "R2");
        for (int i = 0; i < GAP; i++) push(3'd0, 32'h0, 0, 0, 0, 1, 0, disturb ? "R7" : "R3");
        push(3'd2, 32'h1 << idx, 0, 0, 0, 1, 0, disturb ? "R7" : "R4");
        push(3'd2, 32'h1 << idx, 1, 0, 0, 1, 0, disturb ? "R7" : "R4");
        push(3'd3, 32'h0, 0, 1, 0, 1, 0, "R5");
        for (int i = 0; i < n; i++) push(3'd3, 32'h0, 0, 1, 0, 1, 0, to ? "R8" : "R5");
        push(3'd0, 32'h0, 0, 0, 1, 0, to, to ? "R8" : "R6");
        push(3'd0, 32'h0, 0, 0, 0, 0, to, to ? "R8" : "R6");
        push(3'd0, 32'h0, 0, 0, 0, 0, to, to ? "R8" : "R6");
        @(negedge clk);
        start_i = 1'b0;
        sel_i   = 2'(idx + 1);
        if (disturb) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1;
            sel_i   = 2'(idx ^ 3);
            @(negedge clk);
            start_i = 1'b0;
        end
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check('0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check('0, "R1");

        run(0, 3, 0);
        run(1, 0, 0);
        run(2, 1, 0);
        run(3, TO, 0);   // flag clears in the last allowed poll cycle
        run(1, 12, 0);   // stuck flag: poll limit, sticky error
        run(2, 2, 1);    // start and index changes mid-sequence; clears error

        // Reset in the middle of a sequence (R1).
        @(negedge clk);
        model_b = 5;
        start_i = 1'b1;
        sel_i   = 2'd3;
        @(negedge clk);
        start_i = 1'b0;
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check('0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check('0, "R1");
        run(3, 2, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: ends a hung run as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got running exp finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule